// File: doc/BRIEF.md
# Conversion Mode Sequencer

This block decides when a converter produces results and how the ready and error flags around those results behave. The register block passes it the 2-bit mode field and three strobes: a mode-register write, a channel change and the completion of a data read. The block then runs continuous conversions, a one-shot conversion that powers up, converts and powers down again, or a powered-down state. When a conversion completes it emits a one-cycle load strobe together with the result word.

The filter and modulator arithmetic are not part of this block. A stub input supplies a raw result word and two flags, one for over-range and one for under-range. The sequencer clamps the word to all ones or all zeros when a flag is set and raises the error bit. The conversion period, the ready guard interval and the power-up delay are parameters counted in system clock cycles.

The ready bit is active high here and means "do not read". It drops when a fresh result is loaded. It rises again after the result is read, a guard interval before the next update, on a mode-register write, and on entering power-down.

Top module: `conv_seq`

## Requirements
- R1: During and straight after reset, rdy=1, err=0, load=0 and powered=1, and the block starts a continuous conversion with filter settling.
- R2: With mode 2'b00 (continuous), the first load strobe comes 2*PERIOD cycles after the start edge and every later one PERIOD cycles after the previous one. Each load strobe lasts one cycle.
- R3: In the cycle a load strobe is high, result holds the new word and rdy=0.
- R4: A result with the over-range flag is loaded as all ones and one with the under-range flag as all zeros, with err=1. When over-range and under-range are set together, over-range wins. A clean result loads err=0. A mode write or channel change clears err.
- R5: With the result unread, rdy rises exactly GUARD cycles before the next load strobe.
- R6: A data_rd strobe sets rdy on the next cycle. If it coincides with a completing conversion, the new load wins and rdy=0.
- R7: A mode_wr or chan_chg strobe restarts conversion with full settling, so the next load comes 2*PERIOD cycles later. A mode_wr also sets rdy, and a strobe that coincides with a completing conversion suppresses that load.
- R8: Writing mode 2'b10 (single) waits PWRUP cycles, then 2*PERIOD cycles, loads once and drops powered. The result and rdy=0 then persist with no further loads until a read.
- R9: Writing mode 2'b11 (power-down) or the reserved code 2'b01 drops powered, sets rdy and produces no loads.
- R10: An unread result is overwritten by the next conversion's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Mode field from the mode register |
| mode_wr | input | 1 | One-cycle strobe: mode register written |
| chan_chg | input | 1 | One-cycle strobe: input channel changed |
| data_rd | input | 1 | One-cycle strobe: data register read finished |
| res_in | input | W | Raw result word from the filter stub |
| res_ovr | input | 1 | Stub over-range flag |
| res_und | input | 1 | Stub under-range flag |
| load | output | 1 | One-cycle strobe: new result loaded |
| result | output | W | Loaded (clamped) result word |
| rdy | output | 1 | Ready flag, high means no fresh data |
| err | output | 1 | Clamp error flag written with each load |
| powered | output | 1 | Converter powered |

## Verification
A completing conversion can land in the same cycle as a finished data read or as a mode write. The bench provokes both by counting exactly PERIOD-1 cycles after a load and pulsing the strobe so that it is sampled on the completion edge. In the read case, a load must appear with rdy low, because the new word wins. In the mode-write case, no load may appear, rdy must be high, and the next load must come a full two periods later.

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int W      = 24,
  parameter int PERIOD = 40,
  parameter int GUARD  = 4,
  parameter int PWRUP  = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         mode_wr,
  input  logic         chan_chg,
  input  logic         data_rd,
  input  logic [W-1:0] res_in,
  input  logic         res_ovr,
  input  logic         res_und,
  output logic         load,
  output logic [W-1:0] result,
  output logic         rdy,
  output logic         err,
  output logic         powered
);

  localparam int CW = $clog2(2*PERIOD + PWRUP + 1);

  typedef enum logic [1:0] {S_OFF, S_WAKE, S_CONV} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          settle;
  logic          oneshot;

  wire           start = mode_wr | chan_chg;
  wire [CW-1:0]  span  = settle ? CW'(2*PERIOD-1) : CW'(PERIOD-1);
  wire           done  = (st == S_CONV) && (cnt == span);
  wire           guard = (st == S_CONV) && (cnt == span - CW'(GUARD));
  wire           woke  = (st == S_WAKE) && (cnt == CW'(PWRUP-1));
  wire [W-1:0]   clamp = res_ovr ? {W{1'b1}} : (res_und ? {W{1'b0}} : res_in);

  assign powered = (st != S_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_CONV;
      cnt     <= '0;
      settle  <= 1'b1;
      oneshot <= 1'b0;
      load    <= 1'b0;
      result  <= '0;
      rdy     <= 1'b1;
      err     <= 1'b0;
    end else begin
      load <= 1'b0;
      if (start) begin
        cnt    <= '0;
        settle <= 1'b1;
        err    <= 1'b0;
        if (mode_wr || data_rd) rdy <= 1'b1;
        case (mode)
          2'b00: begin st <= S_CONV; oneshot <= 1'b0; end
          2'b10: begin st <= S_WAKE; oneshot <= 1'b1; end
          default: begin st <= S_OFF; rdy <= 1'b1; end
        endcase
      end else if (done) begin
        load   <= 1'b1;
        result <= clamp;
        err    <= res_ovr | res_und;
        rdy    <= 1'b0;
        cnt    <= '0;
        settle <= 1'b0;
        if (oneshot) st <= S_OFF;
      end else begin
        if (woke) begin
          st  <= S_CONV;
          cnt <= '0;
        end else if (st != S_OFF) begin
          cnt <= cnt + 1'b1;
        end
        if (guard || data_rd) rdy <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       mode_wr,
  input logic       chan_chg,
  input logic       load,
  input logic       rdy,
  input logic       err,
  input logic       powered
);

  p_load_rdy_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !rdy);

  p_load_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);

  p_err_with_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> load);

  p_modewr_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (rdy && !err && !load));

  p_pd_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode[0]) |=> (rdy && !powered));

  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!powered && !mode_wr && !chan_chg) |=> (!load && !powered));

endmodule

bind conv_seq conv_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .mode_wr(mode_wr),
  .chan_chg(chan_chg), .load(load), .rdy(rdy), .err(err), .powered(powered)
);

// File: tb/sim_conv_seq.sv
module sim_conv_seq;
  localparam int W = 24, P = 40, G = 4, PU = 20;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b00;
  logic mode_wr = 0, chan_chg = 0, data_rd = 0, res_ovr = 0, res_und = 0;
  logic [W-1:0] res_in = '0;
  logic load, rdy, err, powered;
  logic [W-1:0] result;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  conv_seq #(.W(W), .PERIOD(P), .GUARD(G), .PWRUP(PU)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mode_wr(mode_wr), .chan_chg(chan_chg),
    .data_rd(data_rd), .res_in(res_in), .res_ovr(res_ovr), .res_und(res_und),
    .load(load), .result(result), .rdy(rdy), .err(err), .powered(powered));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int k);
    repeat (k) begin @(posedge clk); #1; end
  endtask

  task automatic wait_load(output int n);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!load && n < 2000);
  endtask

  task automatic count_loads(int k, output int c);
    c = 0;
    repeat (k) begin @(posedge clk); #1; if (load) c++; end
  endtask

  task automatic wr_mode(logic [1:0] m);
    @(negedge clk); mode = m; mode_wr = 1;
    @(posedge clk); #1; mode_wr = 0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); data_rd = 1;
    @(posedge clk); #1; data_rd = 0;
  endtask

  task automatic pulse_chan();
    @(negedge clk); chan_chg = 1;
    @(posedge clk); #1; chan_chg = 0;
  endtask

  task automatic t_reset_cont();
    int n;
    step(3);
    chk("R1 rdy", rdy, 1); chk("R1 err", err, 0);
    chk("R1 load", load, 0); chk("R1 powered", powered, 1);
    res_in = 24'h123456;
    @(negedge clk); rst_n = 1;
    wait_load(n);
    chk("R2 first load delay", n, 2*P);
    chk("R3 result", result, 24'h123456);
    chk("R3 rdy low", rdy, 0);
    chk("R4 clean err", err, 0);
    step(P-G-1); chk("R5 rdy before guard", rdy, 0);
    step(1);     chk("R5 rdy at guard", rdy, 1);
    step(G);     chk("R2 period load", load, 1);
    step(1);     chk("R2 load one cycle", load, 0);
  endtask

  task automatic t_read_overwrite();
    int n;
    pulse_rd();
    chk("R6 read sets rdy", rdy, 1);
    res_in = 24'hAAAAAA;
    wait_load(n);
    chk("R2 period after read", n, P-2);
    res_in = 24'h5A5A5A;
    wait_load(n);
    chk("R10 overwrite", result, 24'h5A5A5A);
    chk("R10 rdy low", rdy, 0);
  endtask

  task automatic t_collide();
    int n;
    step(P-1);
    pulse_rd();
    chk("R6 collide load", load, 1);
    chk("R6 collide rdy", rdy, 0);
    step(P-1);
    wr_mode(2'b00);
    chk("R7 collide no load", load, 0);
    chk("R7 collide rdy", rdy, 1);
    wait_load(n);
    chk("R7 resettle after write", n, 2*P);
    step(5);
    pulse_chan();
    wait_load(n);
    chk("R7 resettle after chan", n, 2*P);
  endtask

  task automatic t_err();
    int n;
    res_ovr = 1;
    wait_load(n);
    chk("R4 ovr clamp", result, {W{1'b1}}); chk("R4 ovr err", err, 1);
    res_ovr = 0; res_und = 1;
    wait_load(n);
    chk("R4 und clamp", result, 0); chk("R4 und err", err, 1);
    res_und = 0;
    wr_mode(2'b00);
    chk("R4 err cleared", err, 0);
    wait_load(n);
    chk("R4 clean after write", err, 0);
  endtask

  task automatic t_single();
    int n, c;
    res_in = 24'h0F0F0F;
    wr_mode(2'b10);
    chk("R8 powered", powered, 1);
    wait_load(n);
    chk("R8 single delay", n, PU + 2*P);
    chk("R8 result", result, 24'h0F0F0F);
    chk("R8 powered off", powered, 0);
    res_in = 24'h111111;
    count_loads(3*P, c);
    chk("R8 no more loads", c, 0);
    chk("R8 rdy persists", rdy, 0);
    chk("R8 result persists", result, 24'h0F0F0F);
    pulse_rd();
    chk("R8 read sets rdy", rdy, 1);
  endtask

  task automatic t_pd();
    int c;
    wr_mode(2'b00);
    step(2*P - 3);
    wr_mode(2'b11);
    chk("R9 pd rdy", rdy, 1); chk("R9 pd powered", powered, 0);
    count_loads(3*P, c);
    pulse_chan();
    count_loads(2*P, c);
    chk("R9 pd no loads", c, 0);
    wr_mode(2'b01);
    chk("R9 reserved powered", powered, 0);
    count_loads(3*P, c);
    chk("R9 reserved no loads", c, 0);
  endtask

  initial begin
    t_reset_cont();
    t_read_overwrite();
    t_collide();
    t_err();
    t_single();
    t_pd();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule